// File: doc/BRIEF.md
# Pulse Phase Width Meter

The meter measures how long an external pulse stays in one chosen level, in cycles of the bus clock. The pulse input is first passed through a synchronizer. A hidden counter then advances once per clock while the synchronized level matches the chosen phase. Outside that phase the counter sits at zero.

When the phase ends, the accumulated count is copied into a readable width register. The copy is skipped if the count overflowed at any point in that phase, so software always reads the last width that was measured cleanly. A policy bit decides what an overflow does: either the meter switches itself off, or the counter wraps and keeps running. Every overflow sets a pending flag, and that flag drives the interrupt output when the interrupt is unmasked.

Software sets the meter up through a small register port, polls or waits for the interrupt, and reads the width back. Reading the status register returns the pending flag and clears it.

Top module: `width_meter`

## Requirements
- R1: After reset, the control register (address 0), interrupt mask (address 1), width register (address 2) and status register (address 3) all read 0, and `irq` is low.
- R2: With control bit 0 (enable) set and control bit 1 (low-phase select) clear, a high pulse held for N clock cycles, where 1 <= N < 2^CNT_W, leaves N in the width register once the input has returned low.
- R3: With control bit 1 set, the low phase is measured instead: a low pulse of N cycles leaves N in the width register.
- R4: While enable is clear, the counter stays at zero, pulses are not measured, and the width register keeps its previous value.
- R5: With control bit 2 (wrap policy) set, an overflow wraps the counter and leaves enable set. A phase in which an overflow occurred does not update the width register.
- R6: With control bit 2 clear, an overflow clears control bit 0 and leaves bits 1 and 2 unchanged. The width register keeps its previous value.
- R7: Every overflow sets status bit 0, whichever overflow policy is selected. `irq` equals status bit 0 ANDed with interrupt-mask bit 0.
- R8: A read of address 3 returns the status and clears status bit 0 at the end of that read cycle.
- R9: A phase of exactly 2^CNT_W-1 cycles is captured as 2^CNT_W-1. A phase of 2^CNT_W cycles counts as an overflow.
- R10: The first clean phase after an overflowed phase is captured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the measurement time base |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| pulseIn | input | 1 | Asynchronous pulse to be measured |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is an overflowed phase that ends with a non-zero count. This happens only under the wrap policy, after the counter has rolled past its maximum and counted further. In that state the width register must keep its old value even though a capture would otherwise take place.

The bench builds the meter with a narrow counter so that overflow takes about a thousand cycles. It drives phases just under, exactly at, and well beyond the wrap length, and it then checks that a short clean phase is captured again. Random widths and random phase selection cover the ordinary measurements in between.

// File: rtl/width_meter_pkg.sv
package width_meter_pkg;

  // Register addresses
  localparam int RegCtrl  = 0;
  localparam int RegMask  = 1;
  localparam int RegWidth = 2;
  localparam int RegStat  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // force counter to zero
    logic inc;      // advance counter
    logic capture;  // load width register from counter
    logic ovf;      // counter wraps past its maximum this cycle
  } meterStrobes_t;

endpackage

// File: rtl/width_meter_ctrl.sv
module width_meter_ctrl
  import width_meter_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pulseIn,
  input  logic              cntAtMax,
  input  logic              cntNonZero,
  input  logic              ovSeen,
  input  logic [CNT_W-1:0]  widthVal,
  output meterStrobes_t     stb,
  output logic              cfgEnable,
  output logic              cfgLowPhase,
  output logic              cfgWrap,
  output logic              irqEnable,
  output logic              irqPending,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(RegCtrl);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(RegMask);
  localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(RegWidth);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(RegStat);

  // Synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncLevel;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= pulseIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pulseIn};
      end
    end
  endgenerate

  assign syncLevel = syncChain[SYNC_STAGES-1];

  // Phase decode and strobe generation
  logic inPhase;
  logic running;

  assign inPhase     = syncLevel ^ cfgLowPhase;
  assign running     = cfgEnable & inPhase;
  assign stb.inc     = running;
  assign stb.clear   = ~running;
  assign stb.ovf     = running & cntAtMax;
  assign stb.capture = cfgEnable & ~inPhase & cntNonZero & ~ovSeen;

  // Configuration registers
  logic ctrlWr;
  logic maskWr;
  logic statRd;

  assign ctrlWr = wrEn && (addr == A_CTRL);
  assign maskWr = wrEn && (addr == A_MASK);
  assign statRd = rdEn && (addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable   <= 1'b0;
      cfgLowPhase <= 1'b0;
      cfgWrap     <= 1'b0;
      irqEnable   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        cfgEnable   <= wrData[0];
        cfgLowPhase <= wrData[1];
        cfgWrap     <= wrData[2];
      end
      // Self-disable policy overrides a same-cycle enable write
      if (stb.ovf && !cfgWrap) begin
        cfgEnable <= 1'b0;
      end
      if (maskWr) begin
        irqEnable <= wrData[0];
      end
    end
  end

  // Pending flag: set beats clear-on-read
  always_ff @(posedge clk) begin
    if (!rstN)        irqPending <= 1'b0;
    else if (stb.ovf) irqPending <= 1'b1;
    else if (statRd)  irqPending <= 1'b0;
  end

  assign irq = irqPending & irqEnable;

  // Read mux
  always_comb begin
    rdData = '0;
    unique case (addr)
      A_CTRL:  rdData[2:0]       = {cfgWrap, cfgLowPhase, cfgEnable};
      A_MASK:  rdData[0]         = irqEnable;
      A_WIDTH: rdData[CNT_W-1:0] = widthVal;
      A_STAT:  rdData[0]         = irqPending;
      default: rdData            = '0;
    endcase
  end

  // Write-data bits above the control field carry no state
  logic unusedWrBits;
  assign unusedWrBits = ^wrData[DATA_W-1:3];

endmodule

// File: rtl/width_meter_datapath.sv
module width_meter_datapath
  import width_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  meterStrobes_t    stb,
  output logic             cntAtMax,
  output logic             cntNonZero,
  output logic             ovSeen,
  output logic [CNT_W-1:0] widthVal
);

  logic [CNT_W-1:0] phaseCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCount <= '0;
      ovSeen     <= 1'b0;
      widthVal   <= '0;
    end else begin
      if (stb.clear)    phaseCount <= '0;
      else if (stb.inc) phaseCount <= phaseCount + CNT_W'(1);

      if (stb.clear)    ovSeen <= 1'b0;
      else if (stb.ovf) ovSeen <= 1'b1;

      if (stb.capture)  widthVal <= phaseCount;
    end
  end

  assign cntAtMax   = &phaseCount;
  assign cntNonZero = |phaseCount;

endmodule

// File: rtl/width_meter.sv
module width_meter
  import width_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pulseIn,
  output logic              irq
);

  meterStrobes_t    stb;
  logic             cntAtMax;
  logic             cntNonZero;
  logic             ovSeen;
  logic [CNT_W-1:0] widthVal;
  logic             cfgEnable;
  logic             cfgLowPhase;
  logic             cfgWrap;
  logic             irqEnable;
  logic             irqPending;

  width_meter_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pulseIn(pulseIn),
    .cntAtMax(cntAtMax), .cntNonZero(cntNonZero), .ovSeen(ovSeen),
    .widthVal(widthVal), .stb(stb), .cfgEnable(cfgEnable),
    .cfgLowPhase(cfgLowPhase), .cfgWrap(cfgWrap), .irqEnable(irqEnable),
    .irqPending(irqPending), .irq(irq)
  );

  width_meter_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntAtMax(cntAtMax),
    .cntNonZero(cntNonZero), .ovSeen(ovSeen), .widthVal(widthVal)
  );

endmodule

// File: rtl/width_meter_chk.sv
module width_meter_chk
  import width_meter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input meterStrobes_t    stb,
  input logic             cntNonZero,
  input logic [CNT_W-1:0] widthVal,
  input logic             cfgEnable,
  input logic             cfgWrap,
  input logic             irqPending
);

  // R4
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !cntNonZero);

  // R2
  width_capture_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(widthVal) |-> $past(stb.capture));

  // R5
  wrap_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ovf && cfgWrap && !wrEn) |=> cfgEnable);

  // R6
  self_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ovf && !cfgWrap) |=> !cfgEnable);

  // R7
  ovf_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ovf |=> irqPending);

  // R8
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPending) |-> $past(rdEn));

endmodule

bind width_meter width_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .stb(stb),
  .cntNonZero(cntNonZero), .widthVal(widthVal), .cfgEnable(cfgEnable),
  .cfgWrap(cfgWrap), .irqPending(irqPending)
);

// File: tb/sim_width_meter.sv
`timescale 1ns/1ps
module sim_width_meter;

  localparam int CW   = 10;
  localparam int MAXW = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        pulseIn = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit lowPh = 1'b0;
  int lastWidth = 0;

  always #5 clk = ~clk;

  width_meter #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pulseIn(pulseIn), .irq(irq)
  );

  function automatic int ctrlWord(bit en, bit lp, bit wr);
    return (int'(wr) << 2) | (int'(lp) << 1) | int'(en);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 2'(a); wrData = 16'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = 2'(a); rdEn = 1'b1;
    #1 d = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setMode(bit lp, bit wrp);
    wr(0, 0);
    lowPh = lp;
    pulseIn = lp;
    repeat (5) @(negedge clk);
    wr(0, ctrlWord(1'b1, lp, wrp));
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    pulseIn = ~lowPh;
    repeat (n) @(negedge clk);
    pulseIn = lowPh;
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 width", v, 0);
    rd(3, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);

    wr(1, 1);
    setMode(1'b0, 1'b0);
    pulse(5);  rd(2, v); chk("R2 width 5", v, 5);
    pulse(1);  rd(2, v); chk("R2 width 1", v, 1);

    setMode(1'b1, 1'b0);
    pulse(12); rd(2, v); chk("R3 low width 12", v, 12);

    // R2 / R3 random widths and phases
    for (int i = 0; i < 20; i++) begin
      bit lp;
      int n;
      lp = 1'($urandom % 2);
      n  = 1 + int'($urandom % 400);
      setMode(lp, 1'b0);
      pulse(n);
      rd(2, v);
      chk(lp ? "R3 random low" : "R2 random high", v, n);
      chk("R7 no irq", int'(irq), 0);
    end

    // R9 largest clean width, then exact overflow under self-disable policy
    setMode(1'b0, 1'b0);
    pulse(MAXW); rd(2, v); chk("R9 max width", v, MAXW);
    lastWidth = MAXW;
    chk("R9 no irq at max", int'(irq), 0);
    pulse(MAXW + 1);
    rd(2, v); chk("R9 overflow keeps width", v, lastWidth);
    rd(0, v); chk("R6 enable cleared", v, 0);
    chk("R7 irq after overflow", int'(irq), 1);
    rd(3, v); chk("R8 status read", v, 1);
    rd(3, v); chk("R8 status cleared", v, 0);
    chk("R8 irq dropped", int'(irq), 0);

    // R4 disabled meter ignores pulses
    pulse(9);
    rd(2, v); chk("R4 width held", v, lastWidth);
    rd(3, v); chk("R4 no status", v, 0);

    // R6 other control bits survive self-disable
    setMode(1'b1, 1'b0);
    pulse(MAXW + 20);
    rd(0, v); chk("R6 low bit kept", v, ctrlWord(1'b0, 1'b1, 1'b0));
    rd(3, v); chk("R7 status self-disable", v, 1);

    // R5 wrap policy: overflowed phase ends with non-zero count
    setMode(1'b0, 1'b1);
    pulse(MAXW + 51);
    rd(2, v); chk("R5 wrapped phase not captured", v, lastWidth);
    rd(0, v); chk("R5 enable kept", v, ctrlWord(1'b1, 1'b0, 1'b1));
    chk("R7 irq under wrap", int'(irq), 1);
    rd(3, v); chk("R8 status under wrap", v, 1);
    pulse(7);
    rd(2, v); chk("R10 clean after overflow", v, 7);

    // R7 masked interrupt still sets status
    wr(1, 0);
    pulse(MAXW + 100);
    chk("R7 masked irq", int'(irq), 0);
    rd(3, v); chk("R7 status masked", v, 1);
    rd(2, v); chk("R5 width after masked ovf", v, 7);

    finishRun();
  end

endmodule